// File: doc/BRIEF.md
# Debug Port Sticky-Error Health Checker

This block runs once a batch of debug-port transactions has been queued and tells the controller whether the port came through the batch cleanly. A start pulse makes it fetch the port's control/status word. The fetch is posted: a control/status read is followed by a read of the read buffer, and the buffer read returns both the acknowledge and the data. While the port answers WAIT, the pair is issued again, up to a bounded number of times. The check then looks at two sticky bits in the word: overrun and error.

If neither sticky bit is set, the check ends cleanly. If one is set and the top nibble of the word shows that debug power is not fully acknowledged, the block raises a power re-initialisation request and does not touch the flags. Otherwise it clears both sticky bits. The clear is a write of the cached control value with the two flag bits ORed in. The block then reads the register back, and fetches the access port's control word and transfer address so the controller can report them. That outcome is always an error.

All traffic leaves through a single command port that feeds a transaction engine. The port carries one command at a time, and the engine answers each command with one response.

Top module: `dbg_health_seq`

## Requirements
- R1: After reset, done_o, err_o, ovr_o, pwr_req_o and cmd_valid_o are 0, and csw_o and tar_o are zero.
- R2: A start pulse makes the block issue a DP read (cmd_op_o=2'b00) of control/status (address 0x04), then a DP read of the read buffer (address 0x0C). The buffer read's response supplies the acknowledge and the status word.
- R3: The acknowledge 3'b001 (WAIT) on the buffer read makes the block re-issue the read pair. After MAX_WAIT consecutive WAIT answers, the check ends with err_o=1 and issues no further command.
- R4: Any buffer-read acknowledge other than 3'b010 (OK) or 3'b001 ends the check at once with err_o=1, ovr_o=0 and pwr_req_o=0.
- R5: With OK and neither the overrun bit (OVR_BIT, default 1) nor the error bit (ERR_BIT, default 5) set, the check ends with err_o=0 and issues no further command.
- R6: With a sticky bit set and status bits [31:28] not all ones, the block sets pwr_req_o=1 and err_o=1, and issues no write.
- R7: With a sticky bit set and bits [31:28] all ones, the block issues a DP write (2'b01) to address 0x04. The write data is the control value sampled at start, ORed with both sticky bits. A read-back pair (0x04, then 0x0C) follows.
- R8: After the read-back, the block issues an AP read (2'b10) of address 0x00 and then address 0x04, each followed by a buffer read. The two buffer results appear on csw_o and tar_o, and err_o=1.
- R9: ovr_o equals the overrun bit of the status word that was evaluated.
- R10: Each check gives exactly one single-cycle done_o pulse. err_o, ovr_o, pwr_req_o, csw_o and tar_o keep their values until the next start.
- R11: start_i is ignored while a check is in progress.
- R12: cmd_valid_o stays asserted with stable op, address and data until cmd_ready_i. No new command is offered while a response is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a health check |
| ctrl_cache_i | input | DATA_W | Cached control value used for the clearing write |
| cmd_valid_o | output | 1 | Command offered to the engine |
| cmd_ready_i | input | 1 | Engine accepts the command |
| cmd_op_o | output | 2 | 00 DP read, 01 DP write, 10 AP read |
| cmd_addr_o | output | ADDR_W | Register address |
| cmd_wdata_o | output | DATA_W | Write data |
| rsp_valid_i | input | 1 | Response for the pending command |
| rsp_ack_i | input | 3 | Acknowledge code |
| rsp_data_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle end-of-check pulse |
| err_o | output | 1 | Check ended in error |
| ovr_o | output | 1 | Sticky overrun seen |
| pwr_req_o | output | 1 | Power re-initialisation requested |
| csw_o | output | DATA_W | Captured access-port control word |
| tar_o | output | DATA_W | Captured transfer address |

## Verification
The bench sweeps every pair of sticky bits against three power nibbles: all ones, one bit missing, and all zero. Each combination runs with zero up to MAX_WAIT WAIT answers before OK. This separates the clean, power-request and clear-and-report branches, and it places the retry limit exactly at its edge. Separate runs feed four illegal acknowledge codes to show that they end the check before any decode. One run pulses start again mid-check to show that the command trace stays the same. An engine model with uneven ready stalls records every command, and each trace is compared with the sequence the requirements predict.

// File: rtl/dbg_health_pkg.sv
package dbg_health_pkg;
  localparam logic [1:0] OP_DP_RD = 2'b00;
  localparam logic [1:0] OP_DP_WR = 2'b01;
  localparam logic [1:0] OP_AP_RD = 2'b10;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  localparam logic [7:0] ADR_DP_STAT  = 8'h04;
  localparam logic [7:0] ADR_DP_RDBUF = 8'h0C;
  localparam logic [7:0] ADR_AP_CSW   = 8'h00;
  localparam logic [7:0] ADR_AP_TAR   = 8'h04;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STAT_POST,
    ST_STAT_FETCH,
    ST_CLR_WR,
    ST_RB_POST,
    ST_RB_FETCH,
    ST_CSW_POST,
    ST_CSW_FETCH,
    ST_TAR_POST,
    ST_TAR_FETCH
  } step_e;

  typedef enum logic [1:0] {
    IS_IDLE,
    IS_SEND,
    IS_WAIT
  } iss_e;
endpackage

// File: rtl/dhs_cmd_issuer.sv
module dhs_cmd_issuer
  import dbg_health_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              idle_o,
  output logic              fin_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic              rsp_valid_i
);
  iss_e              st_q, st_n;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              load_en;

  assign load_en = req_i && (st_q == IS_IDLE);

  always_comb begin
    st_n = st_q;
    case (st_q)
      IS_IDLE: if (req_i) st_n = IS_SEND;
      IS_SEND: if (cmd_ready_i) st_n = IS_WAIT;
      IS_WAIT: if (rsp_valid_i) st_n = IS_IDLE;
      default: st_n = IS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= IS_IDLE;
    else         st_q <= st_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      op_q    <= req_op_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  assign idle_o      = (st_q == IS_IDLE);
  assign fin_o       = (st_q == IS_WAIT) && rsp_valid_i;
  assign cmd_valid_o = (st_q == IS_SEND);
  assign cmd_op_o    = op_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_wdata_o = wdata_q;
endmodule

// File: rtl/dhs_wait_budget.sv
module dhs_wait_budget #(
  parameter int MAX_WAIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign cnt_en = clr_i || inc_i;

  always_comb begin
    cnt_n = cnt_q;
    if (clr_i)      cnt_n = '0;
    else if (inc_i) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign last_o = (cnt_q == CW'(MAX_WAIT - 1));
endmodule

// File: rtl/dhs_status_decode.sv
module dhs_status_decode #(
  parameter int DATA_W  = 32,
  parameter int OVR_BIT = 1,
  parameter int ERR_BIT = 5
) (
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] cache_i,
  output logic              ovr_o,
  output logic              err_o,
  output logic              sticky_o,
  output logic              pwr_ok_o,
  output logic [DATA_W-1:0] clr_word_o
);
  localparam logic [DATA_W-1:0] STICKY_MASK =
    (DATA_W'(1) << OVR_BIT) | (DATA_W'(1) << ERR_BIT);

  assign ovr_o      = stat_i[OVR_BIT];
  assign err_o      = stat_i[ERR_BIT];
  assign sticky_o   = |(stat_i & STICKY_MASK);
  assign pwr_ok_o   = &stat_i[DATA_W-1 -: 4];
  assign clr_word_o = cache_i | STICKY_MASK;
endmodule

// File: rtl/dbg_health_seq.sv
module dbg_health_seq
  import dbg_health_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 8,
  parameter int OVR_BIT  = 1,
  parameter int ERR_BIT  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] ctrl_cache_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [2:0]        rsp_ack_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              done_o,
  output logic              err_o,
  output logic              ovr_o,
  output logic              pwr_req_o,
  output logic [DATA_W-1:0] csw_o,
  output logic [DATA_W-1:0] tar_o
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_DP_STAT);
  localparam logic [ADDR_W-1:0] A_RDBUF = ADDR_W'(ADR_DP_RDBUF);
  localparam logic [ADDR_W-1:0] A_CSW   = ADDR_W'(ADR_AP_CSW);
  localparam logic [ADDR_W-1:0] A_TAR   = ADDR_W'(ADR_AP_TAR);

  step_e             step_q, step_n;
  logic              pend_q, pend_n;
  logic [DATA_W-1:0] cache_q, cache_n;
  logic              done_q, done_n;
  logic              err_q, err_n;
  logic              ovr_q, ovr_n;
  logic              pwr_q, pwr_n;
  logic [DATA_W-1:0] csw_q, csw_n;
  logic [DATA_W-1:0] tar_q, tar_n;

  logic              req;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              iss_idle, iss_fin;
  logic              bud_clr, bud_inc, bud_last;
  logic              dec_ovr, dec_err, dec_sticky, dec_pwr_ok;
  logic [DATA_W-1:0] clr_word;
  logic              start_take;

  dhs_cmd_issuer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_issuer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .req_op_i    (req_op),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .idle_o      (iss_idle),
    .fin_o       (iss_fin),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_op_o    (cmd_op_o),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_wdata_o (cmd_wdata_o),
    .rsp_valid_i (rsp_valid_i)
  );

  dhs_wait_budget #(.MAX_WAIT(MAX_WAIT)) i_budget (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bud_clr),
    .inc_i  (bud_inc),
    .last_o (bud_last)
  );

  dhs_status_decode #(.DATA_W(DATA_W), .OVR_BIT(OVR_BIT), .ERR_BIT(ERR_BIT)) i_decode (
    .stat_i     (rsp_data_i),
    .cache_i    (cache_q),
    .ovr_o      (dec_ovr),
    .err_o      (dec_err),
    .sticky_o   (dec_sticky),
    .pwr_ok_o   (dec_pwr_ok),
    .clr_word_o (clr_word)
  );

  // Command selected by the current step
  always_comb begin
    req_op    = OP_DP_RD;
    req_addr  = A_RDBUF;
    req_wdata = '0;
    case (step_q)
      ST_STAT_POST, ST_RB_POST: req_addr = A_STAT;
      ST_CLR_WR: begin
        req_op    = OP_DP_WR;
        req_addr  = A_STAT;
        req_wdata = clr_word;
      end
      ST_CSW_POST: begin
        req_op   = OP_AP_RD;
        req_addr = A_CSW;
      end
      ST_TAR_POST: begin
        req_op   = OP_AP_RD;
        req_addr = A_TAR;
      end
      default: ;
    endcase
  end

  assign start_take = (step_q == ST_IDLE) && start_i;

  // Next-state process
  always_comb begin
    step_n  = step_q;
    pend_n  = pend_q;
    cache_n = cache_q;
    done_n  = 1'b0;
    err_n   = err_q;
    ovr_n   = ovr_q;
    pwr_n   = pwr_q;
    csw_n   = csw_q;
    tar_n   = tar_q;
    req     = 1'b0;
    bud_clr = 1'b0;
    bud_inc = 1'b0;

    if (step_q == ST_IDLE) begin
      if (start_i) begin
        step_n  = ST_STAT_POST;
        pend_n  = 1'b0;
        cache_n = ctrl_cache_i;
        err_n   = 1'b0;
        ovr_n   = 1'b0;
        pwr_n   = 1'b0;
        csw_n   = '0;
        tar_n   = '0;
        bud_clr = 1'b1;
      end
    end else if (!pend_q) begin
      req = iss_idle;
      if (iss_idle) pend_n = 1'b1;
    end else if (iss_fin) begin
      pend_n = 1'b0;
      case (step_q)
        ST_STAT_POST: step_n = ST_STAT_FETCH;
        ST_STAT_FETCH: begin
          if (rsp_ack_i == ACK_OK) begin
            ovr_n = dec_ovr;
            if (!dec_sticky) begin
              step_n = ST_IDLE;
              done_n = 1'b1;
            end else if (!dec_pwr_ok) begin
              err_n  = 1'b1;
              pwr_n  = 1'b1;
              step_n = ST_IDLE;
              done_n = 1'b1;
            end else begin
              step_n = ST_CLR_WR;
            end
          end else if (rsp_ack_i == ACK_WAIT && !bud_last) begin
            bud_inc = 1'b1;
            step_n  = ST_STAT_POST;
          end else begin
            err_n  = 1'b1;
            step_n = ST_IDLE;
            done_n = 1'b1;
          end
        end
        ST_CLR_WR:   step_n = ST_RB_POST;
        ST_RB_POST:  step_n = ST_RB_FETCH;
        ST_RB_FETCH: step_n = ST_CSW_POST;
        ST_CSW_POST: step_n = ST_CSW_FETCH;
        ST_CSW_FETCH: begin
          csw_n  = rsp_data_i;
          step_n = ST_TAR_POST;
        end
        ST_TAR_POST: step_n = ST_TAR_FETCH;
        ST_TAR_FETCH: begin
          tar_n  = rsp_data_i;
          err_n  = 1'b1;
          step_n = ST_IDLE;
          done_n = 1'b1;
        end
        default: step_n = ST_IDLE;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
      pwr_q  <= 1'b0;
      csw_q  <= '0;
      tar_q  <= '0;
    end else begin
      step_q <= step_n;
      pend_q <= pend_n;
      done_q <= done_n;
      err_q  <= err_n;
      ovr_q  <= ovr_n;
      pwr_q  <= pwr_n;
      csw_q  <= csw_n;
      tar_q  <= tar_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cache_q <= '0;
    else if (start_take) cache_q <= cache_n;
  end

  assign done_o    = done_q;
  assign err_o     = err_q;
  assign ovr_o     = ovr_q;
  assign pwr_req_o = pwr_q;
  assign csw_o     = csw_q;
  assign tar_o     = tar_q;
endmodule

// File: rtl/dbg_health_seq_chk.sv
module dbg_health_seq_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int OVR_BIT = 1,
  parameter int ERR_BIT = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [1:0]        cmd_op_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [DATA_W-1:0] cmd_wdata_o,
  input logic              rsp_valid_i,
  input logic              done_o,
  input logic              err_o,
  input logic              pwr_req_o
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        outst_q <= 1'b0;
    else if (cmd_valid_o && cmd_ready_i) outst_q <= 1'b1;
    else if (rsp_valid_i)               outst_q <= 1'b0;
  end

  a_r12_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o)
      && $stable(cmd_addr_o) && $stable(cmd_wdata_o));

  a_r12_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !cmd_valid_o);

  a_r7_clear_bits_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 2'b01 |-> cmd_wdata_o[OVR_BIT] && cmd_wdata_o[ERR_BIT]);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_pwr_implies_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_req_o |-> err_o);
endmodule

bind dbg_health_seq dbg_health_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVR_BIT(OVR_BIT), .ERR_BIT(ERR_BIT)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_op_o    (cmd_op_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_wdata_o (cmd_wdata_o),
  .rsp_valid_i (rsp_valid_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .pwr_req_o   (pwr_req_o)
);

// File: tb/test_dbg_health_seq.sv
module test_dbg_health_seq;
  localparam int MW = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ctrl_cache_i = '0;
  logic        cmd_valid_o, cmd_ready_i = 1'b0;
  logic [1:0]  cmd_op_o;
  logic [7:0]  cmd_addr_o;
  logic [31:0] cmd_wdata_o;
  logic        rsp_valid_i = 1'b0;
  logic [2:0]  rsp_ack_i = '0;
  logic [31:0] rsp_data_i = '0;
  logic        done_o, err_o, ovr_o, pwr_req_o;
  logic [31:0] csw_o, tar_o;

  always #2.5 clk_i = ~clk_i;

  dbg_health_seq #(.MAX_WAIT(MW)) i_dbg_health_seq (.*);

  int n_chk = 0, n_err = 0;

  // engine model state
  logic [31:0] stat_val, csw_val, tar_val, posted;
  int          waits_left, stall, delay, overlap;
  bit          busy, bad_en;
  logic [2:0]  bad_ack;
  logic [1:0]  log_op[32];
  logic [7:0]  log_adr[32];
  logic [31:0] log_wd[32];
  int          log_n;
  logic [1:0]  exp_op[32];
  logic [7:0]  exp_adr[32];
  logic [31:0] exp_wd[32];
  int          exp_n;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] a, input logic [31:0] wd);
    exp_op[exp_n] = op; exp_adr[exp_n] = a; exp_wd[exp_n] = wd; exp_n++;
  endtask

  // transaction engine, all activity at the falling edge
  initial begin
    busy = 0; stall = 0; delay = 0; overlap = 0; log_n = 0; posted = '0;
    forever begin
      @(negedge clk_i);
      rsp_valid_i = 1'b0;
      cmd_ready_i = 1'b0;
      if (busy) begin
        if (cmd_valid_o) overlap++;
        if (delay == 0) begin rsp_valid_i = 1'b1; busy = 0; end
        else delay--;
      end else if (cmd_valid_o) begin
        if (stall > 0) stall--;
        else begin
          cmd_ready_i = 1'b1;
          if (log_n < 32) begin
            log_op[log_n] = cmd_op_o; log_adr[log_n] = cmd_addr_o; log_wd[log_n] = cmd_wdata_o;
          end
          log_n++;
          rsp_ack_i  = 3'b010;
          rsp_data_i = posted;
          if (cmd_op_o == 2'b00 && cmd_addr_o == 8'h04) posted = stat_val;
          else if (cmd_op_o == 2'b00 && cmd_addr_o == 8'h0C) begin
            if (waits_left > 0) begin rsp_ack_i = 3'b001; waits_left--; end
            else if (bad_en) begin rsp_ack_i = bad_ack; bad_en = 0; end
          end else if (cmd_op_o == 2'b01) stat_val = stat_val & ~(cmd_wdata_o & 32'h22);
          else if (cmd_op_o == 2'b10) posted = (cmd_addr_o == 8'h00) ? csw_val : tar_val;
          busy = 1; delay = 1;
          stall = (log_n % 2 == 1) ? 2 : 0;
        end
      end
    end
  end

  task automatic run_case(input int w, input int fl, input logic [3:0] pwr, input bit bad,
                          input logic [2:0] bcode, input bit restart, input int k);
    int dones;
    logic [31:0] cache;
    bit match;
    string tag;
    cache    = 32'h5000_0F00 + (k << 8);
    stat_val = {pwr, 28'h0123_4C80} | (fl[0] ? 32'h2 : 32'h0) | (fl[1] ? 32'h20 : 32'h0);
    csw_val  = 32'hA200_0012 + k;
    tar_val  = 32'h2000_1000 + 4 * k;
    waits_left = w; bad_en = bad; bad_ack = bcode;
    log_n = 0; exp_n = 0; dones = 0;
    ctrl_cache_i = cache;
    // expected trace from the requirements
    for (int i = 0; i <= ((w < MW) ? w : MW - 1); i++) begin
      push(2'b00, 8'h04, 0); push(2'b00, 8'h0C, 0);
    end
    if (bad) tag = "R4";
    else if (w >= MW) tag = "R3";
    else if (fl == 0) tag = "R5";
    else if (pwr != 4'hF) tag = "R6";
    else begin
      tag = "R8";
      push(2'b01, 8'h04, cache | 32'h22);
      push(2'b00, 8'h04, 0); push(2'b00, 8'h0C, 0);
      push(2'b10, 8'h00, 0); push(2'b00, 8'h0C, 0);
      push(2'b10, 8'h04, 0); push(2'b00, 8'h0C, 0);
    end
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1; ctrl_cache_i = 32'hFFFF_0000;
      @(negedge clk_i); start_i = 1'b0;
      tag = "R11";
    end
    for (int c = 0; c < 160; c++) begin
      @(negedge clk_i);
      if (done_o) dones++;
    end
    check(dones == 1, "R10 one done pulse", dones, 1);
    match = (log_n == exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (log_op[i] != exp_op[i] || log_adr[i] != exp_adr[i] ||
          (exp_op[i] == 2'b01 && log_wd[i] != exp_wd[i])) match = 0;
    // R2 R3 R7 command trace
    check(match, {tag, " command trace"}, log_n, exp_n);
    check(err_o == (tag != "R5" || (restart && fl != 0)), {tag, " err_o"}, err_o,
          (tag != "R5" || (restart && fl != 0)));
    if (!bad && w < MW)
      check(ovr_o == fl[0], "R9 ovr_o", ovr_o, fl[0]);
    else
      check(ovr_o == 0, {tag, " ovr_o clear"}, ovr_o, 0);
    check(pwr_req_o == (!bad && w < MW && fl != 0 && pwr != 4'hF), "R6 pwr_req_o", pwr_req_o,
          (!bad && w < MW && fl != 0 && pwr != 4'hF));
    if (!bad && w < MW && fl != 0 && pwr == 4'hF) begin
      check(csw_o == csw_val && tar_o == tar_val, "R8 csw/tar", csw_o ^ tar_o, csw_val ^ tar_val);
    end else begin
      check(csw_o == 0 && tar_o == 0, {tag, " csw/tar zero"}, csw_o | tar_o, 0);
    end
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!done_o && !err_o && !ovr_o && !pwr_req_o && !cmd_valid_o, "R1 flags at reset",
          {done_o, err_o, ovr_o, pwr_req_o, cmd_valid_o}, 0);
    check(csw_o == 0 && tar_o == 0, "R1 captures at reset", csw_o | tar_o, 0);
    rst_ni = 1'b1;
    for (int w = 0; w <= MW; w++)
      for (int fl = 0; fl < 4; fl++)
        for (int p = 0; p < 3; p++) begin
          run_case(w, fl, (p == 0) ? 4'hF : (p == 1) ? 4'h7 : 4'h0, 0, 3'b000, 0, k);
          k++;
        end
    // R4 illegal acknowledge codes
    run_case(0, 3, 4'hF, 1, 3'b000, 0, k++);
    run_case(0, 3, 4'hF, 1, 3'b100, 0, k++);
    run_case(1, 3, 4'hF, 1, 3'b111, 0, k++);
    run_case(0, 1, 4'hF, 1, 3'b011, 0, k++);
    // R11 second start while busy: trace and clear word unchanged
    run_case(2, 3, 4'hF, 0, 3'b000, 1, k++);
    // R12 no command offered while a response is pending
    check(overlap == 0, "R12 single outstanding", overlap, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule